// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block turns four asynchronous interrupt pins into per-line interrupt requests for a processor. Each pin is brought into the clock domain through a two-stage synchronizer. Software chooses how each synchronized pin is interpreted: level-sensitive at either polarity, edge-sensitive on the rising or the falling transition, or edge-sensitive on both transitions.

Edge events are held in a per-line latch until software acknowledges them. Level requests are never latched. An enable bit per line gates what reaches the request output. Turning the enable bit off only hides a held edge; the edge stays in the latch.

All per-line settings live in one 32-bit configuration word behind a simple write-strobe and read-data port. Each field is four bits wide, and bit n of a field controls line n. Bits [3:0] are the enables and bits [7:4] are the acknowledge strobes. Bits [11:8] are the polarity bits, bits [15:12] are the any-edge bits and bits [19:16] are the level/edge selects. The acknowledge bits act only in the cycle of the write. They are never stored.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0x000F0000. Every line is then level-triggered (bits [19:16] = 1), active-low (bits [11:8] = 0) and disabled (bits [3:0] = 0), and `irq_o` is 0.
- R2: A write stores bits [3:0], [11:8], [15:12] and [19:16] and reads them back from the next cycle. Bits [7:4] and bits [31:20] always read as 0.
- R3: While a line's enable bit (bit n of [3:0]) is 0, `irq_o[n]` is 0. While the enable bit is 1, `irq_o[n]` shows the line's request.
- R4: In level mode (bit 16+n = 1), the request is 1 exactly while the synchronized pin equals the polarity bit (bit 8+n). Polarity 1 means active-high and polarity 0 means active-low. The output follows a pin change 2 clock edges later. It drops 2 edges after the pin returns to its inactive level, with no latching.
- R5: In edge mode (bit 16+n = 0) with the any-edge bit (bit 12+n) at 0, a polarity of 1 latches rising transitions and a polarity of 0 latches falling transitions. The opposite transition is ignored. The latched request appears on `irq_o` 3 clock edges after the pin changes and stays until it is acknowledged.
- R6: In edge mode with the any-edge bit at 1, both rising and falling transitions are latched, whatever the polarity bit holds.
- R7: Writing 1 to bit 4+n clears line n's latch at that write's clock edge. If a new qualifying edge is detected in that same cycle, the latch stays set.
- R8: Clearing the enable bit does not empty the latch. A held edge reappears on `irq_o` when the line is enabled again, unless it was acknowledged in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | LINES (4) | Asynchronous external interrupt pins |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | DATA_W (32) | Configuration write word |
| rd_data | output | DATA_W (32) | Current configuration word; acknowledge bits read 0 |
| irq_o | output | LINES (4) | Per-line interrupt requests |

## Verification
A configuration write becomes visible on `rd_data` after one clock edge. A level-mode request reaches `irq_o` two edges after the pin changes, one edge for each synchronizer flop. An edge-mode request needs a third edge, because the detected edge is registered into the latch. The directed checks step the clock by exactly those counts and sample at the falling edge, so an output that is one cycle early or late fails. The acknowledge-versus-new-edge case is timed so that the write lands on the same edge the latch is set. The random phase runs a cycle-accurate bench model with the same two-flop input pipeline and compares every output at every falling edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    // Per-line configuration as decoded from the shared word
    typedef struct packed {
        logic level;   // 1: level-sensitive, 0: edge-sensitive
        logic sense;   // polarity / edge direction
        logic both;    // any-edge override in edge mode
        logic mask;    // request enable
    } line_cfg_t;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_ANY   = 2'd3
    } trig_e;

    function automatic trig_e trig_of(line_cfg_t c);
        trig_e t;
        if (c.level)      t = TRIG_LEVEL;
        else if (c.both)  t = TRIG_ANY;
        else if (c.sense) t = TRIG_RISE;
        else              t = TRIG_FALL;
        return t;
    endfunction

    function automatic logic edge_hit(trig_e t, logic rise, logic fall);
        logic h;
        case (t)
            TRIG_RISE: h = rise;
            TRIG_FALL: h = fall;
            TRIG_ANY:  h = rise | fall;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg
    import xirq_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output line_cfg_t [LINES-1:0]        cfg_o,
    output logic [LINES-1:0]             ack_o
);
    localparam int OFS_MASK  = 0;
    localparam int OFS_ACK   = LINES;
    localparam int OFS_SENSE = 2 * LINES;
    localparam int OFS_BOTH  = 3 * LINES;
    localparam int OFS_LVL   = 4 * LINES;
    localparam int USED_W    = 5 * LINES;
    localparam logic [DATA_W-1:0] RST_WORD = DATA_W'({LINES{1'b1}}) << OFS_LVL;

    logic [LINES-1:0] mask_q, sense_q, both_q, lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
            lvl_q   <= '1;
        end else if (wr_en) begin
            mask_q  <= wr_data[OFS_MASK  +: LINES];
            sense_q <= wr_data[OFS_SENSE +: LINES];
            both_q  <= wr_data[OFS_BOTH  +: LINES];
            lvl_q   <= wr_data[OFS_LVL   +: LINES];
        end
    end

    // Acknowledge strobes act in the write cycle only
    assign ack_o = wr_en ? wr_data[OFS_ACK +: LINES] : '0;

    always_comb begin
        rd_data = '0;
        rd_data[OFS_MASK  +: LINES] = mask_q;
        rd_data[OFS_SENSE +: LINES] = sense_q;
        rd_data[OFS_BOTH  +: LINES] = both_q;
        rd_data[OFS_LVL   +: LINES] = lvl_q;
    end

    generate
        for (genvar n = 0; n < LINES; n++) begin : g_unpack
            assign cfg_o[n].level = lvl_q[n];
            assign cfg_o[n].sense = sense_q[n];
            assign cfg_o[n].both  = both_q[n];
            assign cfg_o[n].mask  = mask_q[n];
        end
    endgenerate

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == RST_WORD);

    p_write_takes_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[USED_W-1:OFS_SENSE] == $past(wr_data[USED_W-1:OFS_SENSE]))
               && (rd_data[OFS_MASK +: LINES] == $past(wr_data[OFS_MASK +: LINES])));

    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_cfg_t cfg,
    input  logic      ack,
    input  logic      pin_s,
    output logic      req
);
    logic  prev_q;
    logic  lat_q;
    logic  rise, fall, hit;
    logic  level_on;
    trig_e trig;

    assign trig     = trig_of(cfg);
    assign rise     = pin_s & ~prev_q;
    assign fall     = ~pin_s & prev_q;
    assign hit      = edge_hit(trig, rise, fall);
    assign level_on = ~(pin_s ^ cfg.sense);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= pin_s;
            // a fresh edge wins over a same-cycle acknowledge
            lat_q  <= hit | (lat_q & ~ack);
        end
    end

    always_comb begin
        if (trig == TRIG_LEVEL) req = cfg.mask & level_on;
        else                    req = cfg.mask & lat_q;
    end

    p_edge_latches_r5: assert property (@(posedge clk) disable iff (rst)
        hit |=> lat_q);

    p_any_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_ANY && (rise || fall)) |=> lat_q);

    p_ack_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !lat_q);

    p_latch_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (lat_q && !ack) |=> lat_q);

    p_level_ignores_edges_r4: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_LEVEL) |-> !hit);
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  ext_pin,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LINES-1:0]  irq_o
);
    line_cfg_t [LINES-1:0] cfg;
    logic [LINES-1:0]      ack;
    logic [LINES-1:0]      pin_s;

    xirq_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_pin),
        .sync_o  (pin_s)
    );

    xirq_cfg #(.LINES(LINES), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_o   (cfg),
        .ack_o   (ack)
    );

    generate
        for (genvar n = 0; n < LINES; n++) begin : g_line
            xirq_line u_line (
                .clk   (clk),
                .rst   (rst),
                .cfg   (cfg[n]),
                .ack   (ack[n]),
                .pin_s (pin_s[n]),
                .req   (irq_o[n])
            );

            p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
                (!rd_data[n]) |-> !irq_o[n]);
        end
    endgenerate

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_o == '0);
endmodule

// File: tb/test_xirq_ctrl.sv
module test_xirq_ctrl;
    localparam int L  = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [L-1:0]  pins = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [L-1:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xirq_ctrl #(.LINES(L), .DATA_W(DW)) i_xirq_ctrl (
        .clk(clk), .rst(rst), .ext_pin(pins), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq)
    );

    // ---------------- bench model of the requirements ----------------
    logic [L-1:0] m_s1, m_s2, m_prev, m_lat, m_mask, m_sense, m_both, m_lvl, m_hit;

    always_comb begin
        m_hit = ~m_lvl & (((m_s2 & ~m_prev) & (m_sense | m_both)) |
                          ((~m_s2 & m_prev) & (~m_sense | m_both)));
    end

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_lat <= '0;
            m_mask <= '0; m_sense <= '0; m_both <= '0; m_lvl <= '1;
        end else begin
            m_s1   <= pins;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_lat  <= m_hit | (m_lat & ~(wr_en ? wr_data[7:4] : 4'h0));
            if (wr_en) begin
                m_mask  <= wr_data[3:0];
                m_sense <= wr_data[11:8];
                m_both  <= wr_data[15:12];
                m_lvl   <= wr_data[19:16];
            end
        end
    end

    function automatic logic [L-1:0] exp_irq();
        return m_mask & ((m_lvl & ~(m_s2 ^ m_sense)) | (~m_lvl & m_lat));
    endfunction

    function automatic logic [DW-1:0] exp_rd();
        return {12'h0, m_lvl, m_both, m_sense, 4'h0, m_mask};
    endfunction

    function automatic logic [DW-1:0] cw(logic [3:0] mask, logic [3:0] ack,
                                         logic [3:0] sense, logic [3:0] both,
                                         logic [3:0] lvl);
        return {12'h0, lvl, both, sense, ack, mask};
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [DW-1:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick(1);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    function automatic string tag_of(int n);
        if (m_lvl[n])       return "R4";
        else if (m_both[n]) return "R6";
        else                return "R5";
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'h1234_5eed));
        @(negedge clk);
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        chk("R1 reset word", rd_data, 32'h000F_0000);
        chk("R1 reset irq", {28'h0, irq}, 32'h0);

        // R3: enable all; pins low in active-low level mode -> requests
        wr(cw(4'hF, 4'h0, 4'h0, 4'h0, 4'hF));
        chk("R3 enabled active-low", {28'h0, irq}, 32'hF);
        wr(cw(4'h0, 4'h0, 4'h0, 4'h0, 4'hF));
        chk("R3 disabled", {28'h0, irq}, 32'h0);

        // R2: readback, ack and upper bits read zero
        wr(32'hFFFF_FFFF);
        chk("R2 readback", rd_data, 32'h000F_FF0F);
        wr(32'h0);
        chk("R2 zero word", rd_data, 32'h0);

        // R5: line0 rising, line3 falling
        wr(cw(4'b1001, 4'h0, 4'b0001, 4'h0, 4'h0));
        pins[0] = 1'b1; pins[3] = 1'b1;
        tick(2);
        chk("R5 not yet latched", {31'h0, irq[0]}, 32'h0);
        tick(1);
        chk("R5 rising latched", {31'h0, irq[0]}, 32'h1);
        chk("R5 rising ignored on falling line", {31'h0, irq[3]}, 32'h0);
        pins[0] = 1'b0; pins[3] = 1'b0;
        tick(3);
        chk("R5 held until ack", {31'h0, irq[0]}, 32'h1);
        chk("R5 falling latched", {31'h0, irq[3]}, 32'h1);

        // R7: acknowledge clears
        wr(cw(4'b1001, 4'b1001, 4'b0001, 4'h0, 4'h0));
        chk("R7 ack clears", {28'h0, irq}, 32'h0);

        // R7: new edge in the ack cycle wins
        pins[0] = 1'b1;
        tick(2);
        wr(cw(4'b1001, 4'b0001, 4'b0001, 4'h0, 4'h0));
        chk("R7 same-cycle edge wins", {31'h0, irq[0]}, 32'h1);

        // R8: disabling keeps the latch
        wr(cw(4'b1000, 4'h0, 4'b0001, 4'h0, 4'h0));
        chk("R8 hidden while disabled", {31'h0, irq[0]}, 32'h0);
        wr(cw(4'b1001, 4'h0, 4'b0001, 4'h0, 4'h0));
        chk("R8 reappears", {31'h0, irq[0]}, 32'h1);
        wr(cw(4'b1001, 4'b0001, 4'b0001, 4'h0, 4'h0));
        chk("R8 acked", {31'h0, irq[0]}, 32'h0);

        // R6: any-edge on line1
        wr(cw(4'b0010, 4'h0, 4'h0, 4'b0010, 4'h0));
        pins[1] = 1'b1;
        tick(3);
        chk("R6 rise", {31'h0, irq[1]}, 32'h1);
        wr(cw(4'b0010, 4'b0010, 4'h0, 4'b0010, 4'h0));
        chk("R6 acked", {31'h0, irq[1]}, 32'h0);
        pins[1] = 1'b0;
        tick(3);
        chk("R6 fall", {31'h0, irq[1]}, 32'h1);
        wr(cw(4'b0010, 4'b0010, 4'h0, 4'b0010, 4'h0));

        // R4: active-high level on line2, two-edge latency, no latching
        wr(cw(4'b0100, 4'h0, 4'b0100, 4'h0, 4'b0100));
        chk("R4 inactive", {31'h0, irq[2]}, 32'h0);
        pins[2] = 1'b1;
        tick(1);
        chk("R4 one edge late", {31'h0, irq[2]}, 32'h0);
        tick(1);
        chk("R4 asserted", {31'h0, irq[2]}, 32'h1);
        pins[2] = 1'b0;
        tick(2);
        chk("R4 not latched", {31'h0, irq[2]}, 32'h0);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            chk("R2 random readback", rd_data, exp_rd());
            for (int n = 0; n < L; n++) begin
                logic [L-1:0] e;
                e = exp_irq();
                chk(tag_of(n), {31'h0, irq[n]}, {31'h0, e[n]});
            end
            for (int n = 0; n < L; n++)
                if (($urandom % 6) == 0) pins[n] = ~pins[n];
            if (($urandom % 10) == 0) begin
                wr_en = 1'b1;
                wr_data = $urandom;
            end else begin
                wr_en = 1'b0;
                wr_data = '0;
            end
            tick(1);
        end
        wr_en = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule